// File: doc/BRIEF.md
# Inter-processor message queue manager

The block holds fixed-size messages that processors pass to each other over a 32-bit register bus. Each queue is reached through a window of 32 word registers inside a proxy page. The upper sixteen registers of the window carry the message words. A sender fills those words, and its write to the final register places the assembled message on the queue. A receiver reads the same words from the oldest message, and its read of the final register removes that message. A second address region holds one state word per queue. The state word reports the queue's message count and a sticky overflow flag. Every receive queue drives an interrupt line while it holds messages.

Each queue has a fixed direction set at build time. Even-numbered proxy pages see the queue as the build mask defines it. Odd-numbered pages see the opposite direction. So the producer and the consumer of a queue use different pages. Only full-word accesses take effect. Read data comes back on the cycle after the request.

Top module: `msgq_top`

## Requirements
- R1: A data word lives at byte address 0x10000*proxy + 0x80*queue + 4*reg, with bit 20 clear. Only registers 16..31 of a window and proxies 0..NUM_PROXIES-1 (default 2) respond. Accesses to registers 0..15 or to a higher proxy are ignored, and reads of them return zero.
- R2: A write to register 31 commits the staged words 16..30, with the written value as word 31. Words not written since the last commit read as zero. The staging words are cleared after every commit.
- R3: A read of registers 16..30 returns the matching word of the oldest message and changes nothing. A read of register 31 returns its word and removes that message.
- R4: The state word of queue q sits at address (1<<20) + 4*q. It holds the message count in bits 23:12 and the overflow flag in bit 0. All other bits read as zero.
- R5: Each queue holds TOTAL_MSGS/NUM_QUEUES messages (default 2) and delivers them in commit order.
- R6: A commit into a full queue is dropped and sets the overflow flag. A full-word write to the queue's state word clears the flag and changes nothing else.
- R7: A read of an empty queue returns zero and leaves its count at zero.
- R8: irq[q] is high exactly when queue q is a receive queue (RX_MASK bit q = 1; default: odd queues) and its count is nonzero. It stays low for transmit queues.
- R9: Even proxies may write only queues with RX_MASK bit 0 and read only queues with bit 1. Odd proxies have the reverse rights. Writes in the wrong direction are ignored, and reads in the wrong direction return zero without removing anything.
- R10: An access with bus_be other than 4'b1111 is ignored. It stages nothing, commits nothing and removes nothing, and a read of this kind returns zero.
- R11: bus_rvalid is high on the cycle after every read request, carrying bus_rdata, and low otherwise.
- R12: Reset (rst_n low) empties every queue and clears the overflow flags, the staging words and bus_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (21) | Byte address; bit 20 selects the state region |
| bus_be | input | 4 | Byte enables; only 4'b1111 takes effect |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| bus_rdata | output | 32 | Read data |
| irq | output | NUM_QUEUES (64) | Per-queue receive interrupt |

## Verification
The hardest situation to reach is a queue that is already full and receives one more commit. Reaching it needs the producer page to finish two complete messages, and the consumer page must not drain the queue in between. The stimulus then checks that the overflow flag sets, that the count holds, and that the two queued messages still come out in order after the flag is cleared. Another state that is easy to miss is staging residue: words written before a reset or a commit. Directed sequences commit a message right after a reset and right after a previous commit, and expect zeros in every word that was not written. A long random mix of both pages, both directions and partial strobes on four queues is then compared against a behavioural queue model on every clock.

// File: rtl/msgq_pkg.sv
package msgq_pkg;

  // Decoded bus operation, one per cycle
  typedef struct packed {
    logic dat_wr;   // permitted full-word write into a message window
    logic dat_rd;   // permitted full-word read from a message window
    logic last;     // addressed register is the final word of the window
    logic st_rd;    // read of a state word
    logic st_wr;    // write to a state word (clears overflow)
  } msgq_op_t;

endpackage

// File: rtl/msgq_decode.sv
module msgq_decode #(
  parameter int NUM_QUEUES  = 64,
  parameter int NUM_PROXIES = 2,
  parameter int ADDR_W      = 21,
  parameter int QW          = 6,
  parameter int RW          = 5,
  parameter logic [NUM_QUEUES-1:0] RX_MASK = '0
) (
  input  logic                 req,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [3:0]           be,
  output msgq_pkg::msgq_op_t   op,
  output logic [QW-1:0]        qidx,
  output logic [RW-2:0]        widx
);

  localparam int PW = ADDR_W - 17;

  logic          full_word;
  logic          state_rgn;
  logic [PW-1:0] prx;
  logic [RW-1:0] reg_i;
  logic          in_win;
  logic          q_ok;
  logic          p_ok;
  logic          rx_view;
  logic          data_ok;
  logic          unused_addr;

  assign full_word   = (be == 4'hF);
  assign state_rgn   = addr[ADDR_W-1];
  assign prx         = addr[16 +: PW];
  assign reg_i       = addr[2 +: RW];
  assign in_win      = reg_i[RW-1];
  assign qidx        = state_rgn ? addr[2 +: QW] : addr[2+RW +: QW];
  assign widx        = reg_i[RW-2:0];
  assign unused_addr = ^addr;

  if (NUM_QUEUES == (1 << QW)) begin : g_q_all
    assign q_ok = 1'b1;
  end else begin : g_q_part
    assign q_ok = (qidx < QW'(NUM_QUEUES));
  end

  if (NUM_PROXIES == (1 << PW)) begin : g_p_all
    assign p_ok = 1'b1;
  end else begin : g_p_part
    assign p_ok = (prx < PW'(NUM_PROXIES));
  end

  // odd pages see each queue in the opposite direction
  assign rx_view = RX_MASK[qidx] ^ prx[0];
  assign data_ok = req && full_word && !state_rgn && p_ok && q_ok && in_win;

  always_comb begin
    op        = '0;
    op.dat_wr = data_ok && we && !rx_view;
    op.dat_rd = data_ok && !we && rx_view;
    op.last   = &reg_i;
    op.st_rd  = req && full_word && state_rgn && q_ok && !we;
    op.st_wr  = req && full_word && state_rgn && q_ok && we;
  end

endmodule

// File: rtl/msgq_slot.sv
module msgq_slot #(
  parameter int DEPTH  = 2,
  parameter int WORDS  = 16,
  parameter int DW     = 32,
  parameter int WIDX_W = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              commit_en,
  input  logic              pop_en,
  input  logic              clr_ovf,
  input  logic [WIDX_W-1:0] widx,
  input  logic [DW-1:0]     wdata,
  output logic [CNT_W-1:0]  count,
  output logic              ovf,
  output logic [DW-1:0]     head_word
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    stage_q [WORDS];
  logic [DW-1:0]    stage_d [WORDS];
  logic [DW-1:0]    mem_q   [DEPTH][WORDS];
  logic [PTR_W-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             is_full, is_empty, push, pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_full  = (cnt_q == CNT_W'(DEPTH));
  assign is_empty = (cnt_q == '0);
  assign push     = commit_en && !is_full;
  assign pop      = pop_en && !is_empty;

  always_comb begin
    for (int w = 0; w < WORDS; w++) begin
      stage_d[w] = stage_q[w];
      if (commit_en)
        stage_d[w] = '0;
      else if (wr_en && (widx == WIDX_W'(w)))
        stage_d[w] = wdata;
    end
    wptr_d = push ? ptr_next(wptr_q) : wptr_q;
    rptr_d = pop  ? ptr_next(rptr_q) : rptr_q;
    cnt_d  = cnt_q;
    if (push) cnt_d = cnt_q + 1'b1;
    if (pop)  cnt_d = cnt_q - 1'b1;
    ovf_d = ovf_q;
    if (clr_ovf)               ovf_d = 1'b0;
    if (commit_en && is_full)  ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) stage_q[w] <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      for (int w = 0; w < WORDS; w++) stage_q[w] <= stage_d[w];
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  // message storage: no reset, contents qualified by the count
  always_ff @(posedge clk) begin
    if (push) begin
      for (int w = 0; w < WORDS; w++)
        mem_q[wptr_q][w] <= (w == WORDS - 1) ? wdata : stage_q[w];
    end
  end

  assign head_word = is_empty ? '0 : mem_q[rptr_q][widx];
  assign count     = cnt_q;
  assign ovf       = ovf_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R5
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && cnt_q == CNT_W'(DEPTH)) |=> (ovf_q && cnt_q == $past(cnt_q))); // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && cnt_q == '0) |=> (cnt_q == '0)); // R7
  AST_STAGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> (stage_q[0] == '0)); // R2

endmodule

// File: rtl/msgq_top.sv
module msgq_top #(
  parameter int NUM_QUEUES  = 64,
  parameter int TOTAL_MSGS  = 128,
  parameter int WORDS       = 16,
  parameter int NUM_PROXIES = 2,
  parameter int ADDR_W      = 21,
  parameter logic [NUM_QUEUES-1:0] RX_MASK = {(NUM_QUEUES/2){2'b10}}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_req,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [3:0]            bus_be,
  input  logic [31:0]           bus_wdata,
  output logic                  bus_rvalid,
  output logic [31:0]           bus_rdata,
  output logic [NUM_QUEUES-1:0] irq
);

  localparam int DEPTH  = TOTAL_MSGS / NUM_QUEUES;
  localparam int QW     = $clog2(NUM_QUEUES);
  localparam int WIDX_W = $clog2(WORDS);
  localparam int RW     = WIDX_W + 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  msgq_pkg::msgq_op_t op;
  logic [QW-1:0]      qidx;
  logic [WIDX_W-1:0]  widx;
  logic [31:0]        head_w [NUM_QUEUES];
  logic [CNT_W-1:0]   cnt_a  [NUM_QUEUES];
  logic [NUM_QUEUES-1:0] ovf_a;
  logic [31:0]        rdata_d, rdata_q;
  logic               rvalid_d, rvalid_q;

  msgq_decode #(
    .NUM_QUEUES (NUM_QUEUES),
    .NUM_PROXIES(NUM_PROXIES),
    .ADDR_W     (ADDR_W),
    .QW         (QW),
    .RW         (RW),
    .RX_MASK    (RX_MASK)
  ) u_dec (
    .req (bus_req),
    .we  (bus_we),
    .addr(bus_addr),
    .be  (bus_be),
    .op  (op),
    .qidx(qidx),
    .widx(widx)
  );

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_slot
    logic sel;
    assign sel = (qidx == QW'(q));

    msgq_slot #(
      .DEPTH (DEPTH),
      .WORDS (WORDS),
      .DW    (32),
      .WIDX_W(WIDX_W),
      .CNT_W (CNT_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sel && op.dat_wr && !op.last),
      .commit_en(sel && op.dat_wr && op.last),
      .pop_en   (sel && op.dat_rd && op.last),
      .clr_ovf  (sel && op.st_wr),
      .widx     (widx),
      .wdata    (bus_wdata),
      .count    (cnt_a[q]),
      .ovf      (ovf_a[q]),
      .head_word(head_w[q])
    );

    assign irq[q] = RX_MASK[q] && (cnt_a[q] != '0);
  end

  always_comb begin
    rdata_d  = '0;
    rvalid_d = bus_req && !bus_we;
    if (op.dat_rd) begin
      rdata_d = head_w[qidx];
    end else if (op.st_rd) begin
      rdata_d[23:12] = 12'(cnt_a[qidx]);
      rdata_d[0]     = ovf_a[qidx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      if (rvalid_d) rdata_q <= rdata_d;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid); // R11
  AST_SUBWORD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_be != 4'hF) |=> $stable(irq)); // R10

endmodule

// File: tb/tb_msgq_top.sv
module tb_msgq_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NQ = 64;
  localparam logic [NQ-1:0] RXM = {(NQ/2){2'b10}};
  localparam logic [3:0] FULL = 4'hF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_req, bus_we;
  logic [20:0]   bus_addr;
  logic [3:0]    bus_be;
  logic [31:0]   bus_wdata;
  logic          bus_rvalid;
  logic [31:0]   bus_rdata;
  logic [NQ-1:0] irq;

  always #2 clk = ~clk;

  msgq_top dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  bit run_chk = 0;
  bit done = 0;

  // behavioural model: one SV queue of 16-word messages per hardware queue
  logic [511:0] mq  [NQ][$];
  logic [31:0]  stg [NQ][16];
  bit           ovf_m [NQ];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int q = 0; q < NQ; q++) begin
      mq[q].delete();
      ovf_m[q] = 1'b0;
      for (int w = 0; w < 16; w++) stg[q][w] = '0;
    end
  endfunction

  function automatic logic [20:0] daddr(int p, int q, int r);
    return 21'((p << 16) | (q << 7) | (r << 2));
  endfunction

  function automatic logic [20:0] saddr(int q);
    return 21'((1 << 20) | (q << 2));
  endfunction

  function automatic logic [NQ-1:0] exp_irq();
    logic [NQ-1:0] v;
    for (int q = 0; q < NQ; q++) v[q] = RXM[q] && (mq[q].size() != 0);
    return v;
  endfunction

  function automatic logic [31:0] model_apply(bit we, logic [20:0] a, logic [31:0] d, logic [3:0] be);
    int p, q, r;
    bit rxv;
    logic [511:0] m;
    logic [31:0] e;
    e = '0;
    if (be != FULL) return e;
    if (a[20]) begin
      q = int'(a[7:2]);
      if (we) ovf_m[q] = 1'b0;
      else e = {8'h0, 12'(mq[q].size()), 11'h0, ovf_m[q]};
      return e;
    end
    p = int'(a[19:16]);
    q = int'(a[12:7]);
    r = int'(a[6:2]);
    if (p >= 2 || r < 16) return e;
    rxv = RXM[q] ^ p[0];
    if (we && !rxv) begin
      if (r < 31) stg[q][r-16] = d;
      else begin
        for (int w = 0; w < 15; w++) m[w*32 +: 32] = stg[q][w];
        m[480 +: 32] = d;
        if (mq[q].size() < 2) mq[q].push_back(m);
        else ovf_m[q] = 1'b1;
        for (int w = 0; w < 16; w++) stg[q][w] = '0;
      end
    end else if (!we && rxv && mq[q].size() > 0) begin
      m = mq[q][0];
      e = m[(r-16)*32 +: 32];
      if (r == 31) void'(mq[q].pop_front());
    end
    return e;
  endfunction

  task automatic acc(string tag, bit we, logic [20:0] a, logic [31:0] d, logic [3:0] be);
    logic [31:0] e;
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk);
    e = model_apply(we, a, d, be);
    @(negedge clk);
    bus_req = 1'b0;
    chk({tag, " rvalid (R11)"}, 64'(bus_rvalid), 64'(!we));
    if (!we) chk(tag, 64'(bus_rdata), 64'(e));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // per-clock comparison of the interrupt lines (R8)
  always @(negedge clk) begin
    if (run_chk) begin
      #1;
      chk("R8 irq", 64'(irq), 64'(exp_irq()));
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_chk = 1'b1;

    // R12 reset state
    chk("R12 rvalid after reset", 64'(bus_rvalid), 64'(0));
    acc("R12 state q1 empty", 0, saddr(1), 0, FULL);
    acc("R4 state q0 empty", 0, saddr(0), 0, FULL);

    // R2 partial message commit from page 1 into receive queue 1
    acc("R2 stage w16", 1, daddr(1, 1, 16), 32'h1111_0016, FULL);
    acc("R2 stage w17", 1, daddr(1, 1, 17), 32'h1111_0017, FULL);
    acc("R2 commit", 1, daddr(1, 1, 31), 32'hCAFE_0031, FULL);
    acc("R4 count one", 0, saddr(1), 0, FULL);

    // R3 peek and pop
    acc("R3 peek w17", 0, daddr(0, 1, 17), 0, FULL);
    acc("R2 unwritten word zero", 0, daddr(0, 1, 20), 0, FULL);
    acc("R3 peek w16", 0, daddr(0, 1, 16), 0, FULL);
    acc("R3 peek keeps count", 0, saddr(1), 0, FULL);
    acc("R3 pop w31", 0, daddr(0, 1, 31), 0, FULL);
    acc("R3 count after pop", 0, saddr(1), 0, FULL);

    // R5 / R6 fill, overflow, clear, order
    for (int k = 0; k < 3; k++) begin
      acc("R5 stage", 1, daddr(1, 1, 16), 32'hA000_0000 + k, FULL);
      acc("R5 commit", 1, daddr(1, 1, 31), 32'hB000_0000 + k, FULL);
    end
    acc("R6 overflow flag set", 0, saddr(1), 0, FULL);
    acc("R6 clear overflow", 1, saddr(1), 32'h0, FULL);
    acc("R6 flag cleared count kept", 0, saddr(1), 0, FULL);
    acc("R5 first out w16", 0, daddr(0, 1, 16), 0, FULL);
    acc("R5 first out w31", 0, daddr(0, 1, 31), 0, FULL);
    acc("R5 second out w16", 0, daddr(0, 1, 16), 0, FULL);
    acc("R5 second out w31", 0, daddr(0, 1, 31), 0, FULL);

    // R7 empty read
    acc("R7 empty read", 0, daddr(0, 1, 31), 0, FULL);
    acc("R7 count stays zero", 0, saddr(1), 0, FULL);

    // R9 wrong-direction accesses
    acc("R9 wrong write", 1, daddr(0, 1, 16), 32'hDEAD_0001, FULL);
    acc("R9 wrong commit", 1, daddr(0, 1, 31), 32'hDEAD_0002, FULL);
    acc("R9 no message", 0, saddr(1), 0, FULL);
    acc("R9 right commit", 1, daddr(1, 1, 31), 32'h5555_0031, FULL);
    acc("R9 wrong read zero", 0, daddr(1, 1, 31), 0, FULL);
    acc("R9 wrong read no pop", 0, saddr(1), 0, FULL);

    // R10 sub-word accesses
    acc("R10 subword read", 0, daddr(0, 1, 31), 0, 4'h7);
    acc("R10 subword no pop", 0, saddr(1), 0, FULL);
    acc("R10 subword commit", 1, daddr(1, 1, 31), 32'h7777_7777, 4'h3);
    acc("R10 subword no commit", 0, saddr(1), 0, FULL);
    acc("R10 subword state read", 0, saddr(1), 0, 4'h1);
    acc("R10 drain", 0, daddr(0, 1, 31), 0, FULL);

    // R1 window decode
    acc("R1 low register write", 1, daddr(1, 1, 5), 32'h0BAD_0005, FULL);
    acc("R1 low register read", 0, daddr(0, 1, 5), 0, FULL);
    acc("R1 proxy out of range", 1, daddr(2, 1, 31), 32'h0BAD_0031, FULL);
    acc("R1 nothing committed", 0, saddr(1), 0, FULL);
    acc("R1 other queue commit", 1, daddr(1, 5, 31), 32'h0005_0031, FULL);
    acc("R1 other queue read", 0, daddr(0, 5, 31), 0, FULL);

    // R8 transmit queue keeps irq low
    acc("R8 tx stage", 1, daddr(0, 0, 18), 32'h0000_0018, FULL);
    acc("R8 tx commit", 1, daddr(0, 0, 31), 32'h0000_0031, FULL);
    acc("R8 tx count", 0, saddr(0), 0, FULL);
    acc("R8 tx read w18", 0, daddr(1, 0, 18), 0, FULL);
    acc("R8 tx pop", 0, daddr(1, 0, 31), 0, FULL);

    // R2 staging cleared after commit
    acc("R2 stage q2", 1, daddr(0, 2, 16), 32'h2222_2222, FULL);
    acc("R2 commit q2 a", 1, daddr(0, 2, 31), 32'h1, FULL);
    acc("R2 commit q2 b", 1, daddr(0, 2, 31), 32'h2, FULL);
    acc("R2 first w16", 0, daddr(1, 2, 16), 0, FULL);
    acc("R2 first pop", 0, daddr(1, 2, 31), 0, FULL);
    acc("R2 second w16 cleared", 0, daddr(1, 2, 16), 0, FULL);
    acc("R2 second pop", 0, daddr(1, 2, 31), 0, FULL);

    // random mix on queues 0..3
    for (int i = 0; i < 400; i++) begin
      int p, q, r, sel;
      logic [3:0] be;
      p = int'($urandom % 2);
      q = int'($urandom % 4);
      r = 16 + int'($urandom % 16);
      sel = int'($urandom % 10);
      be = ($urandom % 8 == 0) ? 4'h7 : FULL;
      if (sel == 0)      acc("R4 random state read", 0, saddr(q), 0, be);
      else if (sel == 1) acc("R6 random state write", 1, saddr(q), 0, be);
      else if (sel < 6)  acc("R5 random write", 1, daddr(p, q, (sel == 5) ? 31 : r), $urandom, be);
      else               acc("R5 random read", 0, daddr(p, q, (sel == 9) ? 31 : r), 0, be);
    end

    // R12 reset in the middle of traffic
    acc("R12 fill q1", 1, daddr(1, 1, 31), 32'h1234_5678, FULL);
    acc("R12 stage q3", 1, daddr(1, 3, 16), 32'h3333_3333, FULL);
    do_reset();
    acc("R12 q1 emptied", 0, saddr(1), 0, FULL);
    acc("R12 commit after reset", 1, daddr(1, 3, 31), 32'h0000_0003, FULL);
    acc("R12 staging cleared", 0, daddr(0, 3, 16), 0, FULL);
    acc("R12 pop after reset", 0, daddr(0, 3, 31), 0, FULL);

    run_chk = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule